// File: doc/BRIEF.md
# Strap Capture and Frequency Code Selector

This block sits beside the clock synthesizer's output stage and owns a handful of dual-purpose pins. While power-on reset is held, those pins are inputs, and their board-strapped levels are sampled on every clock edge. The first rising edge after reset is released closes the capture. One edge later the block hands the pins back to their clock-output role by raising their output enable, so a pin never drives while its level is being read.

From the captured straps and a few configuration bits supplied by the register file, the block produces a registered five-bit frequency code and a registered AGP rate select for the PLL programming logic. The frequency code can come from the straps or from software. The AGP select can follow its strap or run opposite to it. The captured straps are also presented for readback. A separate mode input decides whether four further shared pins act as extra memory clock outputs or as active-low stop and power-down requests. In the second case the request levels are passed on to the clock gating logic.

Top module: `strap_select_top`

## Requirements
- R1: While porRstN is low, strapOe, sharedSdramOe, effFreqCode and effAgpSel are all 0.
- R2: The strap levels present at the first rising clock edge after porRstN goes high are captured. Strap pin changes after that edge have no effect on fsReadback, agpReadback or the strap-derived effective outputs.
- R3: fsReadback bit i holds the inverse of the level captured on strapFsPin bit i. agpReadback holds the captured strapAgpPin level, not inverted.
- R4: strapOe goes high at the second rising edge after reset release, one edge after the capture closes, and stays high until reset.
- R5: With cfgRegSel at 0, effFreqCode bits 4:1 equal fsReadback bits 3:0 and bit 0 is 0.
- R6: With cfgRegSel at 1, effFreqCode equals cfgFreqCode.
- R7: effAgpSel equals agpReadback XOR cfgAgpToggle, so a toggle value of 1 selects the opposite of the strap.
- R8: effFreqCode and effAgpSel are registered. From the second edge after release, each edge loads them from the inputs present just before it, and they hold between edges.
- R9: With modePin at 0, stopCtrlN is all ones and sharedSdramOe equals strapOe. With modePin at 1, sharedSdramOe is 0 and stopCtrlN equals sharedPinIn. The bits are ordered 0 CPU stop, 1 PCI stop, 2 memory clock stop, 3 power down.
- R10: Asserting porRstN again at any time clears the outputs at once, as in R1. The next release re-captures the straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porRstN | input | 1 | Active-low power-on reset, asynchronous assert |
| strapFsPin | input | 4 | Frequency strap levels on the shared pins |
| strapAgpPin | input | 1 | AGP rate strap level |
| cfgRegSel | input | 1 | 1 selects the software frequency code |
| cfgFreqCode | input | 5 | Software frequency code |
| cfgAgpToggle | input | 1 | 1 inverts the strapped AGP select |
| modePin | input | 1 | Function select for the four control-capable pins |
| sharedPinIn | input | 4 | Levels on the four control-capable pins |
| strapOe | output | 1 | Output enable for the strap pins |
| sharedSdramOe | output | 1 | Output enable for the four pins as memory clocks |
| stopCtrlN | output | 4 | Active-low stop and power-down requests |
| effFreqCode | output | 5 | Registered effective frequency code |
| effAgpSel | output | 1 | Registered effective AGP select |
| fsReadback | output | 4 | Captured frequency straps, inverted |
| agpReadback | output | 1 | Captured AGP strap |

## Verification
Two things can land on the same edge: the capture closing at reset release and a software change of the code source. The bench raises cfgRegSel and deasserts reset in the same cycle. It then moves the strap pins at the capture edge and again after it. Each expected item is derived from a bench-side model of which edge has closed the capture. The design passes only if the software code wins once the output is valid, and the readback still shows the straps sampled at the closing edge.

// File: rtl/strap_pkg.sv
package strap_pkg;
  // Power-on sequencing: sample while in reset, hold one cycle, then run.
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_HOLD   = 2'd1,
    PH_RUN    = 2'd2
  } phase_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic sampleEn;  // capture registers follow the pins this edge
    logic updateEn;  // effective outputs reload this edge
    logic driveEn;   // pins may drive as outputs
  } strobe_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic    clk,
  input  logic    porRstN,
  output strobe_t strobes
);
  phase_t phaseQ, phaseD;

  always_comb begin
    phaseD = phaseQ;
    unique case (phaseQ)
      PH_SAMPLE: phaseD = PH_HOLD;
      PH_HOLD:   phaseD = PH_RUN;
      PH_RUN:    phaseD = PH_RUN;
      default:   phaseD = PH_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) phaseQ <= PH_SAMPLE;
    else          phaseQ <= phaseD;
  end

  always_comb begin
    strobes.sampleEn = (phaseQ == PH_SAMPLE);
    strobes.updateEn = (phaseQ != PH_SAMPLE);
    strobes.driveEn  = (phaseQ == PH_RUN);
  end

  // R4
  drive_after_close_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(strobes.sampleEn) |=> strobes.driveEn);

  // R4
  drive_sticky_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.driveEn |=> strobes.driveEn);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
#(
  parameter int FS_W = 4,
  parameter int SH_W = 4,
  localparam int CODE_W = FS_W + 1
)(
  input  logic              clk,
  input  logic              porRstN,
  input  strobe_t           strobes,
  input  logic [FS_W-1:0]   strapFsPin,
  input  logic              strapAgpPin,
  input  logic              cfgRegSel,
  input  logic [CODE_W-1:0] cfgFreqCode,
  input  logic              cfgAgpToggle,
  input  logic              modePin,
  input  logic [SH_W-1:0]   sharedPinIn,
  output logic              strapOe,
  output logic              sharedSdramOe,
  output logic [SH_W-1:0]   stopCtrlN,
  output logic [CODE_W-1:0] effFreqCode,
  output logic              effAgpSel,
  output logic [FS_W-1:0]   fsReadback,
  output logic              agpReadback
);
  logic [FS_W-1:0]   latchFs;
  logic              latchAgp;
  logic [CODE_W-1:0] nextCode;
  logic              nextAgp;

  // Capture: frequency straps are stored inverted, AGP strap as is.
  always_ff @(posedge clk) begin
    if (strobes.sampleEn) begin
      latchFs  <= ~strapFsPin;
      latchAgp <= strapAgpPin;
    end
  end

  always_comb begin
    nextCode = cfgRegSel ? cfgFreqCode : {latchFs, 1'b0};
    nextAgp  = latchAgp ^ cfgAgpToggle;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      effFreqCode <= '0;
      effAgpSel   <= 1'b0;
    end else if (strobes.updateEn) begin
      effFreqCode <= nextCode;
      effAgpSel   <= nextAgp;
    end
  end

  assign fsReadback    = latchFs;
  assign agpReadback   = latchAgp;
  assign strapOe       = strobes.driveEn;
  assign sharedSdramOe = strobes.driveEn & ~modePin;

  for (genvar i = 0; i < SH_W; i++) begin : g_stop
    assign stopCtrlN[i] = modePin ? sharedPinIn[i] : 1'b1;
  end

  // R2
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !strobes.sampleEn |=> $stable(fsReadback) && $stable(agpReadback));

  // R6
  reg_code_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.updateEn && cfgRegSel |=> effFreqCode == $past(cfgFreqCode));

  // R5
  strap_code_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.updateEn && !cfgRegSel |=> effFreqCode == {fsReadback, 1'b0});

  // R7
  agp_toggle_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strobes.updateEn |=> effAgpSel == ($past(agpReadback) ^ $past(cfgAgpToggle)));

  // R9
  mode_oe_chk: assert property (@(posedge clk) disable iff (!porRstN)
    modePin |-> !sharedSdramOe);
endmodule

// File: rtl/strap_select_top.sv
module strap_select_top
  import strap_pkg::*;
#(
  parameter int FS_W = 4,
  parameter int SH_W = 4
)(
  input  logic            clk,
  input  logic            porRstN,
  input  logic [FS_W-1:0] strapFsPin,
  input  logic            strapAgpPin,
  input  logic            cfgRegSel,
  input  logic [FS_W:0]   cfgFreqCode,
  input  logic            cfgAgpToggle,
  input  logic            modePin,
  input  logic [SH_W-1:0] sharedPinIn,
  output logic            strapOe,
  output logic            sharedSdramOe,
  output logic [SH_W-1:0] stopCtrlN,
  output logic [FS_W:0]   effFreqCode,
  output logic            effAgpSel,
  output logic [FS_W-1:0] fsReadback,
  output logic            agpReadback
);
  strobe_t strobes;

  strap_ctrl u_ctrl (
    .clk     (clk),
    .porRstN (porRstN),
    .strobes (strobes)
  );

  strap_datapath #(.FS_W(FS_W), .SH_W(SH_W)) u_dp (
    .clk           (clk),
    .porRstN       (porRstN),
    .strobes       (strobes),
    .strapFsPin    (strapFsPin),
    .strapAgpPin   (strapAgpPin),
    .cfgRegSel     (cfgRegSel),
    .cfgFreqCode   (cfgFreqCode),
    .cfgAgpToggle  (cfgAgpToggle),
    .modePin       (modePin),
    .sharedPinIn   (sharedPinIn),
    .strapOe       (strapOe),
    .sharedSdramOe (sharedSdramOe),
    .stopCtrlN     (stopCtrlN),
    .effFreqCode   (effFreqCode),
    .effAgpSel     (effAgpSel),
    .fsReadback    (fsReadback),
    .agpReadback   (agpReadback)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !porRstN |-> !strapOe && !sharedSdramOe && effFreqCode == '0 && !effAgpSel);
endmodule

// File: tb/strap_select_top_tb_top.sv
`timescale 1ns/1ps
module strap_select_top_tb_top;
  logic       clk = 1'b0;
  logic       porRstN;
  logic [3:0] strapFsPin;
  logic       strapAgpPin;
  logic       cfgRegSel;
  logic [4:0] cfgFreqCode;
  logic       cfgAgpToggle;
  logic       modePin;
  logic [3:0] sharedPinIn;
  logic       strapOe, sharedSdramOe, effAgpSel, agpReadback;
  logic [3:0] stopCtrlN, fsReadback;
  logic [4:0] effFreqCode;

  always #4 clk = ~clk;

  strap_select_top dut_i (
    .clk(clk), .porRstN(porRstN), .strapFsPin(strapFsPin), .strapAgpPin(strapAgpPin),
    .cfgRegSel(cfgRegSel), .cfgFreqCode(cfgFreqCode), .cfgAgpToggle(cfgAgpToggle),
    .modePin(modePin), .sharedPinIn(sharedPinIn), .strapOe(strapOe),
    .sharedSdramOe(sharedSdramOe), .stopCtrlN(stopCtrlN), .effFreqCode(effFreqCode),
    .effAgpSel(effAgpSel), .fsReadback(fsReadback), .agpReadback(agpReadback)
  );

  typedef struct {
    logic [4:0] code;
    logic       agp;
    logic       oe;
    logic       sdOe;
    logic [3:0] stop;
    logic [3:0] rb;
    logic       rbAgp;
    logic       chkRb;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   fails  = 0;
  int   relCount = 0;
  logic [3:0] mFs;
  logic       mAgp;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle, pushes what the ports must show after the edge.
  task automatic cyc(input string req);
    exp_t e;
    if (!porRstN) relCount = 0;
    if (relCount == 0) begin
      mFs  = ~strapFsPin;
      mAgp = strapAgpPin;
    end
    @(posedge clk);
    if (porRstN) relCount = (relCount < 4) ? relCount + 1 : relCount;
    else relCount = 0;
    e.oe    = (relCount >= 2);
    e.code  = (relCount >= 2) ? (cfgRegSel ? cfgFreqCode : {mFs, 1'b0}) : 5'd0;
    e.agp   = (relCount >= 2) ? (mAgp ^ cfgAgpToggle) : 1'b0;
    e.sdOe  = e.oe & ~modePin;
    e.stop  = modePin ? sharedPinIn : 4'hF;
    e.rb    = mFs;
    e.rbAgp = mAgp;
    e.chkRb = (relCount >= 1);
    e.req   = req;
    expQ.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // Monitor: compares at the falling edge, before the driver moves inputs.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(effFreqCode == e.code, e.req, "effFreqCode", effFreqCode, e.code);
      chk(effAgpSel == e.agp, e.req, "effAgpSel", effAgpSel, e.agp);
      chk(strapOe == e.oe, e.req, "strapOe", strapOe, e.oe);
      chk(sharedSdramOe == e.sdOe, e.req, "sharedSdramOe", sharedSdramOe, e.sdOe);
      chk(stopCtrlN == e.stop, e.req, "stopCtrlN", stopCtrlN, e.stop);
      if (e.chkRb) begin
        chk(fsReadback == e.rb, e.req, "fsReadback(R3)", fsReadback, e.rb);
        chk(agpReadback == e.rbAgp, e.req, "agpReadback(R3)", agpReadback, e.rbAgp);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    porRstN = 1'b0; strapFsPin = 4'b1010; strapAgpPin = 1'b1;
    cfgRegSel = 1'b0; cfgFreqCode = 5'd0; cfgAgpToggle = 1'b1;
    modePin = 1'b0; sharedPinIn = 4'h0;
    #1;
    cyc("R1"); cyc("R1");
    strapFsPin = 4'b0110; strapAgpPin = 1'b0;
    cyc("R1");
    porRstN = 1'b1;
    cyc("R2");                                   // capture closes: 0110 -> rb 1001
    strapFsPin = 4'b1111; strapAgpPin = 1'b1;     // too late, ignored
    cyc("R4");                                   // oe rises, code 10010
    cyc("R5");
    cfgAgpToggle = 1'b0;
    cyc("R7");
    cfgRegSel = 1'b1; cfgFreqCode = 5'b10101;
    cyc("R6");
    cfgFreqCode = 5'b00011;
    cyc("R8");
    modePin = 1'b1; sharedPinIn = 4'b0101;        // bit0 CPU stop ... bit3 power down
    cyc("R9");
    sharedPinIn = 4'b1010;
    cyc("R9");
    modePin = 1'b0;
    cyc("R9");
    cfgRegSel = 1'b0;
    cyc("R5");
    porRstN = 1'b0; strapFsPin = 4'b0001; strapAgpPin = 1'b1; cfgAgpToggle = 1'b1;
    cyc("R10");
    cfgRegSel = 1'b1; cfgFreqCode = 5'b11000; porRstN = 1'b1;   // same-cycle case
    cyc("R2");
    strapFsPin = 4'b0000;
    cyc("R10");
    cfgRegSel = 1'b0;
    cyc("R10");                                  // code {1110,0}
    cyc("R8");
    finishRun();
  end
endmodule